// File: doc/BRIEF.md
# Flash Transfer Page Splitter

This block sits in front of a flash command sequencer. It accepts one transfer request, given as a start address, a total byte count, a direction, a data-phase flag and an addressing-mode flag. It then hands the sequencer a series of sub-operations, one address and byte count at a time. Each sub-operation stays inside one 256-byte aligned page and uses a data-phase length that the sequencer supports: 0 through 7, or a multiple of 8 up to 64.

Sub-operations are offered on a valid/ready handshake. After a sub-operation is accepted, the block waits for a completion pulse from the sequencer. Only then does it work out the next address and length. A completion that reports an error stops the request at once. When the request ends, a single done pulse comes out, together with a status flag.

Unless the request uses absolute flash addressing, a programmable base offset is added to its address. A request without a data phase becomes exactly one command-only sub-operation with a count of zero.

Top module: `flash_chunker`

## Requirements
- R1: No issued sub-operation crosses a 256-byte boundary. When the remaining count would run past the next aligned boundary, the candidate length is cut so that the sub-operation ends exactly at that boundary.
- R2: A candidate length of 64 or more is issued as exactly 64 bytes.
- R3: A candidate length from 8 to 63 is rounded down to a multiple of 8 (low three bits cleared). A candidate length from 1 to 7 is issued unchanged.
- R4: After each successful completion, the next address is the previous address plus the issued count, and the remaining count drops by the issued count. Sub-operations continue until the remaining count reaches zero.
- R5: When `req_has_data` is 0, the requested count is ignored. Exactly one sub-operation with `op_count` = 0 is issued.
- R6: When `req_linear` is 0, the first sub-operation address is `req_addr + base_offset` (modulo 2^ADDR_W). When `req_linear` is 1, it is `req_addr`.
- R7: While a sub-operation is awaiting completion, `op_valid` stays low. While `op_valid` is high and `op_ready` is low, `op_addr` and `op_count` hold steady.
- R8: A completion with `op_cpl_err` = 1 ends the request. On the next cycle, `done` = 1 and `done_err` = 1, and no further sub-operation is issued.
- R9: When the last sub-operation completes without error, `done` pulses for one cycle with `done_err` = 0, and `req_ready` returns to 1 in the following cycle.
- R10: After reset, `req_ready` = 1, `op_valid` = 0 and `done` = 0.
- R11: `op_write` carries the `req_write` value captured when the request was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | ADDR_W | Request start address |
| req_count | input | CNT_W | Total byte count |
| req_write | input | 1 | 1 = data goes to flash |
| req_has_data | input | 1 | Request carries a data phase |
| req_linear | input | 1 | Address is absolute, skip base offset |
| base_offset | input | ADDR_W | Offset added to non-absolute addresses |
| op_valid | output | 1 | Sub-operation offered |
| op_ready | input | 1 | Sequencer accepts the sub-operation |
| op_addr | output | ADDR_W | Sub-operation flash address |
| op_count | output | LEN_W | Sub-operation byte count (0..64) |
| op_write | output | 1 | Sub-operation direction |
| op_cpl | input | 1 | Completion pulse of the accepted sub-operation |
| op_cpl_err | input | 1 | Completion reported an error |
| done | output | 1 | One-cycle pulse: request finished |
| done_err | output | 1 | Status with done: 1 = ended by error |

## Verification
The assertions assume that the sequencer raises `op_cpl` only for a sub-operation it has accepted and not yet completed, and only once for each. They also assume that `req_valid` is raised only while `req_ready` is high. The stimulus follows both rules. It offers a request only at an idle cycle, then tracks each accepted sub-operation and gives it exactly one completion pulse after a random delay. Ready delays, the error injection rate, and addresses near page ends all vary under a fixed seed.

// File: rtl/flash_chunk_pkg.sv
package flash_chunk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } chunk_state_t;
endpackage

// File: rtl/chunk_len_calc.sv
module chunk_len_calc #(
  parameter int ADDR_W     = 24,
  parameter int CNT_W      = 16,
  parameter int PAGE_BYTES = 256,
  parameter int MAX_CHUNK  = 64,
  parameter int GRAIN      = 8,
  localparam int PAGE_W    = $clog2(PAGE_BYTES),
  localparam int LEN_W     = $clog2(MAX_CHUNK + 1)
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [CNT_W-1:0]  remaining,
  output logic [LEN_W-1:0]  len
);
  localparam logic [LEN_W-1:0] GRAIN_MASK = ~LEN_W'(GRAIN - 1);

  logic [CNT_W-1:0] to_edge;
  logic [CNT_W-1:0] raw;

  // bytes left before the next page boundary (1..PAGE_BYTES)
  assign to_edge = CNT_W'(PAGE_BYTES) - CNT_W'(cur_addr[PAGE_W-1:0]);

  always_comb begin
    raw = (remaining < to_edge) ? remaining : to_edge;
    if (raw >= CNT_W'(MAX_CHUNK)) begin
      len = LEN_W'(MAX_CHUNK);
    end else if (raw >= CNT_W'(GRAIN)) begin
      len = LEN_W'(raw) & GRAIN_MASK;
    end else begin
      len = LEN_W'(raw);
    end
  end
endmodule

// File: rtl/chunk_ctrl.sv
module chunk_ctrl
  import flash_chunk_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16,
  parameter int LEN_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  start_count,
  input  logic              start_write,
  output logic              idle,
  input  logic [LEN_W-1:0]  len,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [CNT_W-1:0]  remaining,
  output logic              op_valid,
  input  logic              op_ready,
  output logic              op_write,
  input  logic              op_cpl,
  input  logic              op_cpl_err,
  output logic              done,
  output logic              done_err
);
  chunk_state_t      state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic              wr_q, wr_d;
  logic              err_q, err_d;
  logic              data_en;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    rem_d   = rem_q;
    wr_d    = wr_q;
    err_d   = err_q;
    data_en = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_valid) begin
          addr_d  = start_addr;
          rem_d   = start_count;
          wr_d    = start_write;
          err_d   = 1'b0;
          data_en = 1'b1;
          state_d = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (op_ready) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (op_cpl) begin
          data_en = 1'b1;
          if (op_cpl_err) begin
            err_d   = 1'b1;
            state_d = ST_DONE;
          end else begin
            addr_d  = addr_q + ADDR_W'(len);
            rem_d   = rem_q - CNT_W'(len);
            state_d = (rem_q == CNT_W'(len)) ? ST_DONE : ST_ISSUE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      wr_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (data_en) begin
        addr_q <= addr_d;
        rem_q  <= rem_d;
        wr_q   <= wr_d;
        err_q  <= err_d;
      end
    end
  end

  assign idle      = (state_q == ST_IDLE);
  assign op_valid  = (state_q == ST_ISSUE);
  assign done      = (state_q == ST_DONE);
  assign done_err  = done & err_q;
  assign cur_addr  = addr_q;
  assign remaining = rem_q;
  assign op_write  = wr_q;
endmodule

// File: rtl/flash_chunker.sv
module flash_chunker #(
  parameter int ADDR_W     = 24,
  parameter int CNT_W      = 16,
  parameter int PAGE_BYTES = 256,
  parameter int MAX_CHUNK  = 64,
  parameter int GRAIN      = 8,
  localparam int LEN_W     = $clog2(MAX_CHUNK + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_count,
  input  logic              req_write,
  input  logic              req_has_data,
  input  logic              req_linear,
  input  logic [ADDR_W-1:0] base_offset,
  output logic              op_valid,
  input  logic              op_ready,
  output logic [ADDR_W-1:0] op_addr,
  output logic [LEN_W-1:0]  op_count,
  output logic              op_write,
  input  logic              op_cpl,
  input  logic              op_cpl_err,
  output logic              done,
  output logic              done_err
);
  logic [ADDR_W-1:0] start_addr;
  logic [CNT_W-1:0]  start_count;
  logic [ADDR_W-1:0] cur_addr;
  logic [CNT_W-1:0]  remaining;
  logic [LEN_W-1:0]  len;

  assign start_addr  = req_linear ? req_addr : (req_addr + base_offset);
  assign start_count = req_has_data ? req_count : '0;

  chunk_len_calc #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_BYTES(PAGE_BYTES),
    .MAX_CHUNK(MAX_CHUNK), .GRAIN(GRAIN)
  ) i_len (
    .cur_addr (cur_addr),
    .remaining(remaining),
    .len      (len)
  );

  chunk_ctrl #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LEN_W(LEN_W)
  ) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_valid(req_valid),
    .start_addr (start_addr),
    .start_count(start_count),
    .start_write(req_write),
    .idle       (req_ready),
    .len        (len),
    .cur_addr   (cur_addr),
    .remaining  (remaining),
    .op_valid   (op_valid),
    .op_ready   (op_ready),
    .op_write   (op_write),
    .op_cpl     (op_cpl),
    .op_cpl_err (op_cpl_err),
    .done       (done),
    .done_err   (done_err)
  );

  assign op_addr  = cur_addr;
  assign op_count = len;
endmodule

// File: rtl/flash_chunker_chk.sv
module flash_chunker_chk #(
  parameter int ADDR_W     = 24,
  parameter int PAGE_BYTES = 256,
  parameter int MAX_CHUNK  = 64,
  parameter int GRAIN      = 8,
  parameter int LEN_W      = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              op_valid,
  input logic              op_ready,
  input logic [ADDR_W-1:0] op_addr,
  input logic [LEN_W-1:0]  op_count,
  input logic              op_cpl,
  input logic              op_cpl_err,
  input logic              done,
  input logic              done_err
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);

  logic pending;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= 1'b0;
    else if (op_valid && op_ready) pending <= 1'b1;
    else if (op_cpl) pending <= 1'b0;
  end

  assert_page_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> (int'(op_addr[PAGE_W-1:0]) + int'(op_count) <= PAGE_BYTES));

  assert_max_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> (int'(op_count) <= MAX_CHUNK));

  assert_grain_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && int'(op_count) >= GRAIN) |-> (int'(op_count) % GRAIN == 0));

  assert_one_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> !op_valid);

  assert_hold_offer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_ready) |=> (op_valid && $stable(op_addr) && $stable(op_count)));

  assert_err_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && op_cpl && op_cpl_err) |=> (done && done_err && !op_valid));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));
endmodule

bind flash_chunker flash_chunker_chk #(
  .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .MAX_CHUNK(MAX_CHUNK),
  .GRAIN(GRAIN), .LEN_W(LEN_W)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .op_valid  (op_valid),
  .op_ready  (op_ready),
  .op_addr   (op_addr),
  .op_count  (op_count),
  .op_cpl    (op_cpl),
  .op_cpl_err(op_cpl_err),
  .done      (done),
  .done_err  (done_err)
);

// File: tb/test_flash_chunker.sv
`timescale 1ns/1ps
module test_flash_chunker;
  localparam int ADDR_W = 24;
  localparam int CNT_W  = 16;
  localparam int LEN_W  = 7;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [CNT_W-1:0]  req_count = '0;
  logic              req_write = 1'b0;
  logic              req_has_data = 1'b0;
  logic              req_linear = 1'b0;
  logic [ADDR_W-1:0] base_offset = '0;
  logic              op_valid;
  logic              op_ready = 1'b0;
  logic [ADDR_W-1:0] op_addr;
  logic [LEN_W-1:0]  op_count;
  logic              op_write;
  logic              op_cpl = 1'b0;
  logic              op_cpl_err = 1'b0;
  logic              done;
  logic              done_err;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  flash_chunker i_flash_chunker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_count(req_count), .req_write(req_write), .req_has_data(req_has_data),
    .req_linear(req_linear), .base_offset(base_offset),
    .op_valid(op_valid), .op_ready(op_ready), .op_addr(op_addr),
    .op_count(op_count), .op_write(op_write), .op_cpl(op_cpl),
    .op_cpl_err(op_cpl_err), .done(done), .done_err(done_err)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // legal length from requirements R1, R2, R3
  function automatic int exp_len(input int addr, input int rem);
    int edge_left, raw;
    edge_left = 256 - (addr % 256);
    raw = (rem < edge_left) ? rem : edge_left;
    if (raw >= 64) return 64;
    if (raw >= 8) return raw - (raw % 8);
    return raw;
  endfunction

  task automatic run_req(input int addr, input int cnt, input bit wr,
                         input bit has_data, input bit linear, input int base,
                         input int err_rate);
    int  eaddr, rem, len, guard;
    bit  finished, first, err;
    @(negedge clk);
    guard = 0;
    while (!req_ready && guard < 100) begin @(negedge clk); guard++; end
    req_addr = ADDR_W'(addr); req_count = CNT_W'(cnt); req_write = wr;
    req_has_data = has_data; req_linear = linear; base_offset = ADDR_W'(base);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    eaddr = linear ? addr : ((addr + base) % (1 << ADDR_W));
    rem = has_data ? cnt : 0;
    finished = 0; first = 1;
    while (!finished) begin
      guard = 0;
      while (!op_valid && guard < 50) begin @(negedge clk); guard++; end
      len = exp_len(eaddr, rem);
      if (first) begin
        if (!linear) check(op_addr == ADDR_W'(eaddr), "R6 offset added", op_addr, eaddr);
        else check(op_addr == ADDR_W'(eaddr), "R6 linear no offset", op_addr, eaddr);
        if (!has_data) check(op_count == 0, "R5 command only count", op_count, 0);
      end else begin
        check(op_addr == ADDR_W'(eaddr), "R4 address advance", op_addr, eaddr);
      end
      check(op_count == LEN_W'(len), "R1 R2 R3 chunk length", op_count, len);
      check(op_write == wr, "R11 direction", op_write, wr);
      first = 0;
      repeat ($urandom_range(0, 3)) begin
        @(negedge clk);
        check(op_valid && op_addr == ADDR_W'(eaddr) && op_count == LEN_W'(len),
              "R7 offer held", op_count, len);
      end
      op_ready = 1'b1;
      @(negedge clk);
      op_ready = 1'b0;
      repeat ($urandom_range(0, 4)) begin
        check(!op_valid, "R7 no offer while pending", op_valid, 0);
        @(negedge clk);
      end
      err = (err_rate > 0) && ($urandom_range(0, err_rate - 1) == 0);
      op_cpl = 1'b1; op_cpl_err = err;
      @(negedge clk);
      op_cpl = 1'b0; op_cpl_err = 1'b0;
      if (err) begin
        check(done && done_err && !op_valid, "R8 error ends request", {done, done_err}, 2'b11);
        finished = 1;
      end else begin
        eaddr = (eaddr + len) % (1 << ADDR_W);
        rem = rem - len;
        if (rem == 0) begin
          check(done && !done_err, "R9 done ok", {done, done_err}, 2'b10);
          finished = 1;
        end else begin
          check(!done, "R4 continues while remaining", done, 0);
        end
      end
    end
    @(negedge clk);
    check(!done && req_ready, "R9 back to idle", {done, req_ready}, 2'b01);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready && !op_valid && !done, "R10 reset state",
          {req_ready, op_valid, done}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !op_valid && !done, "R10 idle after reset",
          {req_ready, op_valid, done}, 3'b100);
    void'($urandom(32'h5eed1));
    // directed corners
    run_req(32'hF8, 20, 1'b0, 1'b1, 1'b1, 0, 0);        // R1 cut to boundary
    run_req(32'h1000, 200, 1'b1, 1'b1, 1'b1, 0, 0);     // R2 cap 64
    run_req(32'h2003, 13, 1'b0, 1'b1, 1'b1, 0, 0);      // R3 13 -> 8 then 5
    run_req(32'h30FE, 5, 1'b0, 1'b1, 1'b1, 0, 0);       // R1 small cut 2 then 3
    run_req(32'h4000, 77, 1'b1, 1'b0, 1'b0, 32'h100, 0);// R5 no data, R6 offset
    run_req(32'h0, 0, 1'b0, 1'b1, 1'b1, 0, 0);          // R5 zero count
    run_req(32'hFFFFF0, 40, 1'b0, 1'b1, 1'b0, 32'h20, 0); // R6 wrap
    run_req(32'h5000, 300, 1'b1, 1'b1, 1'b1, 0, 1);     // R8 error on first
    // constrained random
    for (int i = 0; i < 80; i++) begin
      int a;
      a = $urandom_range(0, 32'hFFFFF);
      if ($urandom_range(0, 2) == 0) a = (a & 32'hFFFF00) | $urandom_range(240, 255);
      run_req(a, $urandom_range(0, 600), 1'($urandom_range(0, 1)),
              ($urandom_range(0, 7) != 0), 1'($urandom_range(0, 1)),
              $urandom_range(0, 32'hFFFF), 16);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule